// File: doc/BRIEF.md
# First-Order Delta-Sigma Modulator Controller

This block is the digital half of a first-order delta-sigma converter. The integrator and the comparator sit outside it. The comparator tells the block whether the external RC integrator is below or above its reference. The single feedback output acts as a 1-bit DAC that pushes charge into the integrator or pulls it out.

While idle, the feedback output simply mirrors the comparator, which parks the integrator at the reference. A start pulse runs a conversion of 2^RES_BITS modulator cycles, each exactly CYCLE_CLKS clocks long. During a conversion the feedback is a registered copy of the synchronized comparator, taken once per cycle. The block counts the cycles whose sample found the integrator above the reference. After the last cycle it latches that count into the result register, pulses done for one clock and returns the feedback to passthrough.

Top module: `sd_mod_ctrl`

## Requirements
- R1: While no conversion runs, `fb_o` equals `cmp_i` with no clock delay.
- R2: A `start_i` seen high at a clock edge while idle begins a conversion: `busy_o` is high after that edge, and the cycle and ones counters are cleared, so no earlier conversion affects the result.
- R3: During a conversion `fb_o` is registered and changes only at modulator-cycle boundaries. At boundary k (clock edge CYCLE_CLKS·k after the start edge) it takes the comparator sample. `cmp_i` = 1 means the integrator is below the reference and drives feedback 1; `cmp_i` = 0 drives feedback 0. The comparator passes a two-flop synchronizer, so a level must be present two edges before the boundary.
- R4: The result is the number of boundaries whose sample was 0 (integrator above the reference).
- R5: A conversion makes exactly 2^RES_BITS decisions and lasts 2^RES_BITS·CYCLE_CLKS clocks. `busy_o` falls and `done_o` rises at the edge of the final boundary.
- R6: `done_o` is high for exactly one clock, together with the new `result_o`. `result_o` holds its value until the next conversion completes.
- R7: `result_o` is RES_BITS+1 bits wide. An input that is 0 for every boundary reports 2^RES_BITS without wrap, and an input that is 1 for every boundary reports 0.
- R8: A `start_i` while `busy_o` is high is ignored. The running conversion keeps its timing and result.
- R9: After synchronous reset `busy_o` and `done_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, acted on only while idle |
| cmp_i | input | 1 | Asynchronous comparator, 1 = integrator below reference |
| fb_o | output | 1 | 1-bit DAC drive to the integrator, 1 = add charge |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock pulse with a fresh result |
| result_o | output | RES_BITS+1 | Count of above-reference decisions |

## Verification
The comparator is driven with one level per modulator cycle. Constant high and constant low patterns pin the two ends of the scale, and the low one shows the full count fits without wrapping. An alternating pattern and an irregular pattern show that every decision is counted once and lands in the right cycle, because the feedback is compared against the previous cycle's level at each boundary. Back-to-back conversions with different patterns show the clear on start, and a start pulse injected mid-conversion shows that the timing and result of the running conversion do not move.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sd_state_e;
endpackage

// File: rtl/sd_sync2.sv
// Two-flop synchronizer for the asynchronous comparator level.
module sd_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sd_cycle_timer.sv
// Divides the clock into equal modulator cycles; tick marks each boundary.
module sd_cycle_timer #(
  parameter int CYCLE_CLKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(CYCLE_CLKS - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      phase_q <= '0;
    end else if (run_i) begin
      if (phase_q == PH_LAST) phase_q <= '0;
      else                    phase_q <= phase_q + 1'b1;
    end
  end

  assign tick_o = run_i && (phase_q == PH_LAST);
endmodule

// File: rtl/sd_ones_acc.sv
// Cycle counter and above-reference counter for one conversion.
module sd_ones_acc #(
  parameter int RES_BITS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              above_i,
  output logic              last_o,
  output logic [RES_BITS:0] sum_o
);
  logic [RES_BITS-1:0] cyc_q;
  logic [RES_BITS:0]   acc_q;

  assign sum_o  = acc_q + {{RES_BITS{1'b0}}, above_i};
  assign last_o = &cyc_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cyc_q <= '0;
      acc_q <= '0;
    end else if (step_i) begin
      cyc_q <= cyc_q + 1'b1;
      acc_q <= sum_o;
    end
  end
endmodule

// File: rtl/sd_mod_ctrl.sv
module sd_mod_ctrl #(
  parameter int RES_BITS   = 10,
  parameter int CYCLE_CLKS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic              fb_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [RES_BITS:0] result_o
);
  import sd_pkg::*;

  sd_state_e         state_q;
  logic              cmp_s;
  logic              fb_q;
  logic              tick;
  logic              last;
  logic              start_ok;
  logic              running;
  logic [RES_BITS:0] sum;

  assign running  = (state_q == ST_RUN);
  assign start_ok = start_i && !running;

  sd_sync2 u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_i),
    .q_o (cmp_s)
  );

  sd_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_ok),
    .run_i   (running),
    .tick_o  (tick)
  );

  sd_ones_acc #(.RES_BITS(RES_BITS)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_ok),
    .step_i  (tick),
    .above_i (~cmp_s),
    .last_o  (last),
    .sum_o   (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      fb_q     <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_ok) begin
        state_q <= ST_RUN;
        fb_q    <= cmp_s;
      end else if (tick) begin
        fb_q <= cmp_s;
        if (last) begin
          state_q  <= ST_IDLE;
          result_o <= sum;
          done_o   <= 1'b1;
        end
      end
    end
  end

  assign busy_o = running;
  // Idle: comparator drives the DAC directly; running: clocked decision.
  assign fb_o   = running ? fb_q : cmp_i;
endmodule

// File: rtl/sd_mod_ctrl_chk.sv
module sd_mod_ctrl_chk #(
  parameter int RES_BITS   = 10,
  parameter int CYCLE_CLKS = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              cmp_i,
  input logic              fb_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [RES_BITS:0] result_o
);
  localparam int          CONV_CLKS = (1 << RES_BITS) * CYCLE_CLKS;
  localparam logic [RES_BITS:0] FULL = (RES_BITS+1)'(1 << RES_BITS);

  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_len <= 0;
    else                busy_len <= busy_len + 1;
  end

  a_r1_idle_follow: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (fb_o == cmp_i));

  a_r2_start_accepted: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r5_length: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (busy_len == CONV_CLKS && !busy_o));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    result_o <= FULL);

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && busy_len < CONV_CLKS) |=> busy_o);
endmodule

bind sd_mod_ctrl sd_mod_ctrl_chk #(
  .RES_BITS   (RES_BITS),
  .CYCLE_CLKS (CYCLE_CLKS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .cmp_i    (cmp_i),
  .fb_o     (fb_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/sd_mod_ctrl_tb.sv
`timescale 1ns/1ps
module sd_mod_ctrl_tb;
  localparam int RB   = 4;
  localparam int CC   = 6;
  localparam int NCYC = 1 << RB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          cmp_i = 1'b1;
  logic          fb_o, busy_o, done_o;
  logic [RB:0]   result_o;

  int checks = 0;
  int fails  = 0;
  int last_expected = 0;
  bit finished = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  sd_mod_ctrl #(.RES_BITS(RB), .CYCLE_CLKS(CC)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .fb_o(fb_o), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: each done pulse pops one expected result (R4, R6).
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected done", 1, 0);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R4 result", int'(result_o), e);
      end
    end
  end

  // Driver: one comparator level per modulator cycle, pat[k-1] for cycle k.
  task automatic run_conv(input logic [NCYC-1:0] pat, input bit poke);
    int zeros = 0;
    for (int i = 0; i < NCYC; i++) if (!pat[i]) zeros++;
    exp_q.push_back(zeros);
    last_expected = zeros;
    start_i = 1'b1;
    @(posedge clk);            // start edge S
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    for (int k = 1; k <= NCYC; k++) begin
      @(posedge clk);
      @(negedge clk);          // after edge S+(k-1)*CC+1
      if (k > 1) check("R3 feedback decision", int'(fb_o), int'(pat[k-2]));
      cmp_i = pat[k-1];
      for (int w = 0; w < CC - 1; w++) begin
        @(posedge clk);
        @(negedge clk);
        if (poke && k == 2 && w == 1) start_i = 1'b1;
        else start_i = 1'b0;
      end
      if (k < NCYC) check("R5 busy through conversion", int'(busy_o), 1);
    end
    check("R5 done at final boundary", int'(done_o), 1);
    check("R5 busy cleared at end", int'(busy_o), 0);
    @(posedge clk);
    @(negedge clk);
    check("R6 done one cycle", int'(done_o), 0);
    check("R6 result held", int'(result_o), last_expected);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 busy after reset", int'(busy_o), 0);
    check("R9 done after reset", int'(done_o), 0);
    check("R9 result after reset", int'(result_o), 0);

    // R1: idle passthrough with no clock delay
    cmp_i = 1'b0; #1;
    check("R1 passthrough low", int'(fb_o), 0);
    cmp_i = 1'b1; #1;
    check("R1 passthrough high", int'(fb_o), 1);
    @(negedge clk);

    run_conv({NCYC{1'b1}}, 1'b0);             // R7: all below -> 0
    check("R7 all-high gives zero", int'(result_o), 0);
    run_conv({NCYC{1'b0}}, 1'b0);             // R7: full scale, no wrap
    check("R7 full scale", int'(result_o), NCYC);
    run_conv(16'hAAAA, 1'b0);                 // alternating
    run_conv(16'h1234, 1'b1);                 // R8: start poked mid-run; R2: fresh clear
    check("R8 result unaffected by busy start", int'(result_o), 11);

    cmp_i = 1'b0; #1;
    check("R1 passthrough after conversion", int'(fb_o), 0);
    repeat (4) @(negedge clk);
    check("R6 no extra done", exp_q.size(), 0);
    finish_up();
  end
endmodule